// File: doc/BRIEF.md
# Prioritized Flash Command Queue

This block holds the pending write and block-erase commands of one flash page, between the command decoder and the engine that runs the program and erase algorithms. Each arriving command carries a block number and that block's lock bit. The queue decides at once whether it may enter. It keeps pending writes and pending erases in two ordered lists, and it always shows the engine one head command, chosen by class priority.

Writes are held in a small first-in first-out store that shares a common limit of three entries with the erases. When no write is pending, erases alone may fill one slot per block, so all 32 blocks can wait for erase together. A write whose block already has an erase waiting moves that erase to the front of the erase list, so the block is rewritten as soon as possible. A second erase request for a block that is already pending is merged into the first. A synchronous active-low flush input, driven from the page's reset/power-down pin, discards everything.

Top module: `flash_cmd_queue`

## Requirements
- R1: After `rst`, `q_empty` is 1 and `head_valid`, `cmd_acc`, `cmd_rej_full`, `lock_err`, `q_full_wr` and `q_full_er` are all 0.
- R2: With no write pending, erases to distinct blocks are all accepted until NBLK (32) are pending, and `q_full_er` is then 1. `q_full_wr` is 1 whenever the writes and erases pending together number at least WR_DEPTH (3).
- R3: A write offered while `q_full_wr` is 1 is refused. A new-block erase offered while `q_full_er` is 1 is refused, and that flag is also 1 when any write is pending and the total is at least 3. A refused command gives `cmd_rej_full`=1 and `cmd_acc`=0 in the cycle after it is offered, and it adds no entry. Fullness is judged on occupancy before that cycle's dispatch.
- R4: Within one class, commands are dispatched in the order they were accepted. An accepted command gives `cmd_acc`=1 in the next cycle.
- R5: While any write is pending, the head is the oldest write (`head_erase`=0). Erases are dispatched only when no write is pending. A dispatch happens on a cycle with `take`=1 and `head_valid`=1.
- R6: An accepted write whose block has a pending erase moves that erase to the front of the erase list, ahead of all other pending erases.
- R7: With `wp_n`=0, a command whose `cmd_locked` is 1 is rejected. It adds no entry, `cmd_acc` and `cmd_rej_full` stay 0, and the sticky `lock_err` becomes 1 in the next cycle.
- R8: With `wp_n`=1, `cmd_locked` has no effect, and such a command is admitted like an unlocked one.
- R9: A cycle with `flush_n`=0 empties both lists, clears `lock_err` and drops any command offered in that cycle. `q_empty` is 1 in the next cycle.
- R10: An erase for a block whose erase is already pending is acknowledged with `cmd_acc`=1 even when `q_full_er` is 1. It takes no second entry, so that block is dispatched once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush_n | input | 1 | Synchronous active-low flush of all pending commands |
| wp_n | input | 1 | Write-protect; 0 enforces lock bits |
| cmd_valid | input | 1 | A command is offered this cycle |
| cmd_erase | input | 1 | 1 = block erase, 0 = write |
| cmd_block | input | BLKW (5) | Target block number |
| cmd_locked | input | 1 | Lock bit of the target block |
| take | input | 1 | Engine takes the head command |
| head_valid | output | 1 | A command is pending |
| head_erase | output | 1 | Head command is an erase |
| head_block | output | BLKW (5) | Block of the head command |
| cmd_acc | output | 1 | Previous cycle's command was accepted or merged |
| cmd_rej_full | output | 1 | Previous cycle's command was refused for lack of room |
| lock_err | output | 1 | Sticky: a command to a locked block was rejected |
| q_empty | output | 1 | No command pending |
| q_full_wr | output | 1 | No room for a write |
| q_full_er | output | 1 | No room for an erase to a new block |

## Verification
The bench fills the erase list with all 32 blocks in a scrambled order and drains it. A design that capped erases at the normal depth, or that lost its order when the list shifted, would refuse entries or dispatch blocks out of sequence. It checks that a write overtakes erases queued earlier and that an erase already in the list moves forward when its block is written; an unprioritized FIFO would dispatch in arrival order. Duplicate erases, locked commands under both write-protect levels, refusal of an erase while a write is pending, and a flush that coincides with an offered command are each checked for an added entry or a missing one, and for a wrong pulse or a lock flag that does not stick or does not clear.

// File: rtl/fq_pkg.sv
package fq_pkg;
  // Outcome of the admission decision for the command offered this cycle
  typedef enum logic [1:0] {
    RES_NONE = 2'd0,
    RES_ACC  = 2'd1,
    RES_FULL = 2'd2,
    RES_LOCK = 2'd3
  } fq_res_e;
endpackage

// File: rtl/fq_admit.sv
module fq_admit
  import fq_pkg::*;
#(
  parameter int NBLK     = 32,
  parameter int WR_DEPTH = 3,
  parameter int WCW      = 2,
  parameter int ECW      = 6
) (
  input  logic           flush_n,
  input  logic           wp_n,
  input  logic           cmd_valid,
  input  logic           cmd_erase,
  input  logic           cmd_locked,
  input  logic           er_hit,
  input  logic [WCW-1:0] wr_cnt,
  input  logic [ECW-1:0] er_cnt,
  output fq_res_e        res,
  output logic           push_wr,
  output logic           push_er,
  output logic           promote,
  output logic           full_wr,
  output logic           full_er
);
  localparam int TW = ECW + 1;

  logic [TW-1:0] total;
  logic          lock_block;

  always_comb begin
    total      = TW'(wr_cnt) + TW'(er_cnt);
    full_wr    = (total >= TW'(WR_DEPTH));
    full_er    = (wr_cnt != '0) ? full_wr : (er_cnt >= ECW'(NBLK));
    lock_block = cmd_locked && !wp_n;
  end

  always_comb begin
    res     = RES_NONE;
    push_wr = 1'b0;
    push_er = 1'b0;
    promote = 1'b0;
    if (flush_n && cmd_valid) begin
      if (lock_block) begin
        res = RES_LOCK;
      end else if (cmd_erase) begin
        if (er_hit) begin
          res = RES_ACC;              // merged into the pending entry
        end else if (full_er) begin
          res = RES_FULL;
        end else begin
          res     = RES_ACC;
          push_er = 1'b1;
        end
      end else begin
        if (full_wr) begin
          res = RES_FULL;
        end else begin
          res     = RES_ACC;
          push_wr = 1'b1;
          promote = er_hit;
        end
      end
    end
  end
endmodule

// File: rtl/fq_write_fifo.sv
module fq_write_fifo #(
  parameter int DEPTH = 3,
  parameter int BLKW  = 5,
  parameter int CW    = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            flush,
  input  logic            push,
  input  logic            pop,
  input  logic [BLKW-1:0] din,
  output logic [BLKW-1:0] head,
  output logic [CW-1:0]   cnt
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [BLKW-1:0] mem [DEPTH];
  logic [PW-1:0]   rd_ptr, wr_ptr;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  // Storage without reset so it can map onto RAM
  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      cnt <= cnt + CW'(push) - CW'(pop);
    end
  end

  assign head = mem[rd_ptr];

  // R3
  fifo_no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    push |-> (cnt < CW'(DEPTH)));

  // R5
  fifo_no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    pop |-> (cnt != '0));
endmodule

// File: rtl/fq_erase_list.sv
module fq_erase_list #(
  parameter int NBLK = 32,
  parameter int BLKW = 5,
  parameter int CNTW = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            flush,
  input  logic            push,
  input  logic            pop,
  input  logic            promote,
  input  logic [BLKW-1:0] blk,
  output logic [BLKW-1:0] head,
  output logic [CNTW-1:0] cnt,
  output logic [NBLK-1:0] pend
);
  logic [BLKW-1:0] ord_q [NBLK];
  logic [BLKW-1:0] ord_a [NBLK];
  logic [BLKW-1:0] ord_b [NBLK];
  logic [BLKW-1:0] ord_n [NBLK];
  logic [CNTW-1:0] cnt_a, cnt_n;
  logic [NBLK-1:0] pend_a, pend_n;
  logic [CNTW-1:0] hit_idx;
  logic            hit;

  // Stage A: dispatch removes the front entry and shifts the rest forward
  always_comb begin
    cnt_a  = cnt - CNTW'(pop);
    pend_a = pend;
    if (pop) pend_a[ord_q[0]] = 1'b0;
    for (int j = 0; j < NBLK - 1; j++)
      ord_a[j] = pop ? ord_q[j+1] : ord_q[j];
    ord_a[NBLK-1] = ord_q[NBLK-1];
  end

  // Stage B: a new erase joins at the tail
  always_comb begin
    for (int j = 0; j < NBLK; j++)
      ord_b[j] = (push && (CNTW'(j) == cnt_a)) ? blk : ord_a[j];
  end

  // Stage C: a write to a pending block pulls its erase to the front
  always_comb begin
    hit     = promote && pend_a[blk];
    hit_idx = '0;
    for (int j = 0; j < NBLK; j++)
      if ((ord_a[j] == blk) && (CNTW'(j) < cnt_a)) hit_idx = CNTW'(j);
    ord_n[0] = hit ? blk : ord_b[0];
    for (int j = 1; j < NBLK; j++)
      ord_n[j] = (hit && (CNTW'(j) <= hit_idx)) ? ord_b[j-1] : ord_b[j];
  end

  always_comb begin
    cnt_n  = cnt_a + CNTW'(push);
    pend_n = pend_a;
    if (push) pend_n[blk] = 1'b1;
  end

  always_ff @(posedge clk) begin
    for (int j = 0; j < NBLK; j++) ord_q[j] <= ord_n[j];
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      cnt  <= '0;
      pend <= '0;
    end else begin
      cnt  <= cnt_n;
      pend <= pend_n;
    end
  end

  assign head = ord_q[0];

  // R10
  pend_matches_count_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(pend) == int'(cnt));

  // R2
  erase_capacity_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNTW'(NBLK));

  // R10
  no_duplicate_push_chk: assert property (@(posedge clk) disable iff (rst)
    push |-> !pend[blk]);
endmodule

// File: rtl/flash_cmd_queue.sv
module flash_cmd_queue
  import fq_pkg::*;
#(
  parameter int NBLK     = 32,
  parameter int WR_DEPTH = 3,
  parameter int BLKW     = $clog2(NBLK)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            flush_n,
  input  logic            wp_n,
  input  logic            cmd_valid,
  input  logic            cmd_erase,
  input  logic [BLKW-1:0] cmd_block,
  input  logic            cmd_locked,
  input  logic            take,
  output logic            head_valid,
  output logic            head_erase,
  output logic [BLKW-1:0] head_block,
  output logic            cmd_acc,
  output logic            cmd_rej_full,
  output logic            lock_err,
  output logic            q_empty,
  output logic            q_full_wr,
  output logic            q_full_er
);
  localparam int WCW = $clog2(WR_DEPTH + 1);
  localparam int ECW = $clog2(NBLK + 1);

  logic [WCW-1:0]  wr_cnt;
  logic [ECW-1:0]  er_cnt;
  logic [NBLK-1:0] er_pend;
  logic [BLKW-1:0] wr_head, er_head;
  logic            push_wr, push_er, promote;
  logic            pop_wr, pop_er;
  logic            flush;
  fq_res_e         res;

  assign flush = !flush_n;

  fq_admit #(
    .NBLK(NBLK), .WR_DEPTH(WR_DEPTH), .WCW(WCW), .ECW(ECW)
  ) u_admit (
    .flush_n   (flush_n),
    .wp_n      (wp_n),
    .cmd_valid (cmd_valid),
    .cmd_erase (cmd_erase),
    .cmd_locked(cmd_locked),
    .er_hit    (er_pend[cmd_block]),
    .wr_cnt    (wr_cnt),
    .er_cnt    (er_cnt),
    .res       (res),
    .push_wr   (push_wr),
    .push_er   (push_er),
    .promote   (promote),
    .full_wr   (q_full_wr),
    .full_er   (q_full_er)
  );

  always_comb begin
    pop_wr = flush_n && take && (wr_cnt != '0);
    pop_er = flush_n && take && (wr_cnt == '0) && (er_cnt != '0);
  end

  fq_write_fifo #(
    .DEPTH(WR_DEPTH), .BLKW(BLKW), .CW(WCW)
  ) u_wr (
    .clk  (clk),
    .rst  (rst),
    .flush(flush),
    .push (push_wr),
    .pop  (pop_wr),
    .din  (cmd_block),
    .head (wr_head),
    .cnt  (wr_cnt)
  );

  fq_erase_list #(
    .NBLK(NBLK), .BLKW(BLKW), .CNTW(ECW)
  ) u_er (
    .clk    (clk),
    .rst    (rst),
    .flush  (flush),
    .push   (push_er),
    .pop    (pop_er),
    .promote(promote),
    .blk    (cmd_block),
    .head   (er_head),
    .cnt    (er_cnt),
    .pend   (er_pend)
  );

  always_comb begin
    head_valid = (wr_cnt != '0) || (er_cnt != '0);
    head_erase = (wr_cnt == '0) && (er_cnt != '0);
    head_block = (wr_cnt != '0) ? wr_head : er_head;
    q_empty    = !head_valid;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_acc      <= 1'b0;
      cmd_rej_full <= 1'b0;
      lock_err     <= 1'b0;
    end else begin
      cmd_acc      <= (res == RES_ACC);
      cmd_rej_full <= (res == RES_FULL);
      if (flush)                lock_err <= 1'b0;
      else if (res == RES_LOCK) lock_err <= 1'b1;
    end
  end

  // R7
  lock_reject_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && flush_n && !wp_n && cmd_locked) |=> (!cmd_acc && lock_err));

  // R9
  flush_empties_chk: assert property (@(posedge clk) disable iff (rst)
    !flush_n |=> (q_empty && !lock_err));

  // R3
  single_outcome_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cmd_acc, cmd_rej_full}));

  // R3
  write_total_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_cnt != '0) |-> ((int'(wr_cnt) + int'(er_cnt)) <= WR_DEPTH));
endmodule

// File: tb/flash_cmd_queue_bench.sv
module flash_cmd_queue_bench;
  localparam int NBLK = 32;
  localparam int BLKW = 5;

  logic clk = 1'b0;
  logic rst, flush_n, wp_n, cmd_valid, cmd_erase, cmd_locked, take;
  logic [BLKW-1:0] cmd_block;
  logic head_valid, head_erase, cmd_acc, cmd_rej_full, lock_err;
  logic q_empty, q_full_wr, q_full_er;
  logic [BLKW-1:0] head_block;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  flash_cmd_queue #(.NBLK(NBLK), .WR_DEPTH(3)) u_flash_cmd_queue (
    .clk(clk), .rst(rst), .flush_n(flush_n), .wp_n(wp_n),
    .cmd_valid(cmd_valid), .cmd_erase(cmd_erase), .cmd_block(cmd_block),
    .cmd_locked(cmd_locked), .take(take),
    .head_valid(head_valid), .head_erase(head_erase), .head_block(head_block),
    .cmd_acc(cmd_acc), .cmd_rej_full(cmd_rej_full), .lock_err(lock_err),
    .q_empty(q_empty), .q_full_wr(q_full_wr), .q_full_er(q_full_er)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Offer one command; outcome flags are read at the following falling edge
  task automatic send(input logic er, input int blk, input logic lk);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_erase = er; cmd_block = BLKW'(blk); cmd_locked = lk;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_locked = 1'b0;
  endtask

  task automatic send_ok(input string tag, input logic er, input int blk);
    send(er, blk, 1'b0);
    check({tag, " acc"}, int'(cmd_acc), 1);
  endtask

  task automatic pop_exp(input string tag, input logic er, input int blk);
    @(negedge clk);
    check({tag, " head_valid"}, int'(head_valid), 1);
    check({tag, " head_erase"}, int'(head_erase), int'(er));
    check({tag, " head_block"}, int'(head_block), blk);
    take = 1'b1;
    @(negedge clk);
    take = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst = 1'b1; flush_n = 1'b1; wp_n = 1'b1; cmd_valid = 1'b0;
    cmd_erase = 1'b0; cmd_block = '0; cmd_locked = 1'b0; take = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check("R1 empty", int'(q_empty), 1);
    check("R1 head_valid", int'(head_valid), 0);
    check("R1 flags", int'({cmd_acc, cmd_rej_full, lock_err, q_full_wr, q_full_er}), 0);

    // R2 erase sweep over every block in a scrambled order
    for (int i = 0; i < NBLK; i++) send_ok("R2 sweep", 1'b1, (i * 7) % NBLK);
    check("R2 full_er", int'(q_full_er), 1);
    check("R2 full_wr", int'(q_full_wr), 1);
    // R10 duplicate erase merged while full
    send(1'b1, 5, 1'b0);
    check("R10 merge acc", int'(cmd_acc), 1);
    // R3 write refused
    send(1'b0, 1, 1'b0);
    check("R3 write rej", int'(cmd_rej_full), 1);
    check("R3 write not acc", int'(cmd_acc), 0);
    // R4 erase order preserved, one entry per block
    for (int i = 0; i < NBLK; i++) pop_exp("R4 erase fifo", 1'b1, (i * 7) % NBLK);
    check("R10 drained", int'(q_empty), 1);

    // R5 write overtakes earlier erases; R3 erase refused while a write waits
    send_ok("R5 e10", 1'b1, 10);
    send_ok("R5 e11", 1'b1, 11);
    send_ok("R5 w3", 1'b0, 3);
    check("R3 full_er with write", int'(q_full_er), 1);
    send(1'b1, 12, 1'b0);
    check("R3 erase rej", int'(cmd_rej_full), 1);
    pop_exp("R5 write first", 1'b0, 3);
    pop_exp("R5 then e10", 1'b1, 10);
    pop_exp("R5 then e11", 1'b1, 11);
    check("R3 refused erase absent", int'(q_empty), 1);

    // R6 promotion of the written block's erase
    send_ok("R6 e2", 1'b1, 2);
    send_ok("R6 e9", 1'b1, 9);
    send_ok("R6 w9", 1'b0, 9);
    pop_exp("R6 write", 1'b0, 9);
    pop_exp("R6 promoted", 1'b1, 9);
    pop_exp("R6 other", 1'b1, 2);

    // R4 write order
    send_ok("R4 w1", 1'b0, 1);
    send_ok("R4 w2", 1'b0, 2);
    send_ok("R4 w3", 1'b0, 3);
    check("R2 full_wr", int'(q_full_wr), 1);
    pop_exp("R4 w1 out", 1'b0, 1);
    pop_exp("R4 w2 out", 1'b0, 2);
    pop_exp("R4 w3 out", 1'b0, 3);

    // R7 locked blocks under write protect
    wp_n = 1'b0;
    send(1'b1, 4, 1'b1);
    check("R7 erase acc", int'(cmd_acc), 0);
    check("R7 erase rej_full", int'(cmd_rej_full), 0);
    check("R7 lock_err", int'(lock_err), 1);
    check("R7 no entry", int'(q_empty), 1);
    send(1'b0, 4, 1'b1);
    check("R7 write acc", int'(cmd_acc), 0);
    check("R7 still empty", int'(q_empty), 1);
    check("R7 sticky", int'(lock_err), 1);
    // R8 lock bit ignored when protect is released
    wp_n = 1'b1;
    send(1'b0, 7, 1'b1);
    check("R8 locked write acc", int'(cmd_acc), 1);
    pop_exp("R8 entry", 1'b0, 7);

    // R9 flush with a command offered in the same cycle
    send_ok("R9 e1", 1'b1, 1);
    send_ok("R9 w2", 1'b0, 2);
    @(negedge clk);
    flush_n = 1'b0; cmd_valid = 1'b1; cmd_erase = 1'b1; cmd_block = 5'd3;
    @(negedge clk);
    flush_n = 1'b1; cmd_valid = 1'b0;
    check("R9 empty", int'(q_empty), 1);
    check("R9 lock_err cleared", int'(lock_err), 0);
    check("R9 dropped cmd", int'(cmd_acc), 0);
    @(negedge clk);
    check("R9 stays empty", int'(head_valid), 0);

    // R10 duplicate erase takes one entry
    send_ok("R10 e6", 1'b1, 6);
    send_ok("R10 e6 again", 1'b1, 6);
    pop_exp("R10 single", 1'b1, 6);
    @(negedge clk);
    check("R10 empty after one", int'(q_empty), 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule